// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a 32-bit integer core. Each cycle it takes an operation code, a first operand from the register file, a second operand that the barrel shifter has already prepared, the shifter's carry-out, the current N, Z, C and V condition flags and a set-flags bit. It produces a result, a write enable for the destination register and the next value of the four flags.

The operations cover plain and carry-chained addition, forward and reverse subtraction with and without the carry, the bitwise operations including bit clear, move and move-inverted, four flag-only comparison and test forms, and a leading-zero count. The arithmetic forms and the logic forms follow different flag rules. The compare and test forms always update flags and never write a result. The combinational datapath feeds one output register stage with a synchronous active-low reset, so every output belongs to the operation presented one clock edge earlier.

Top module: `dp_alu`

## Requirements
- R1: Opcode 0x04 (add) gives first + second and opcode 0x05 (add with carry) gives first + second + C; with set-flags, C becomes the carry out of bit 31 and V becomes signed overflow.
- R2: Opcode 0x02 (subtract) gives first − second and opcode 0x06 (subtract with carry) gives first − second − (1 − C); with set-flags, C becomes 1 exactly when no borrow occurs and V becomes signed overflow.
- R3: Opcode 0x03 (reverse subtract) gives second − first and opcode 0x07 (reverse subtract with carry) gives second − first − (1 − C), with the same C and V rules as R2.
- R4: Opcodes 0x00 AND, 0x01 exclusive-or, 0x0C OR and 0x0E bit clear (first AND NOT second) write the bitwise result.
- R5: Opcode 0x0D (move) writes the second operand and opcode 0x0F (move inverted) writes its bitwise complement.
- R6: For every logic and test opcode (0x00, 0x01, 0x08, 0x09, 0x0C, 0x0D, 0x0E, 0x0F) that updates flags, C takes the shifter carry-out and V keeps its current value.
- R7: When set-flags is 0, opcodes 0x00–0x07 and 0x0C–0x0F write their result and pass all four flags through unchanged.
- R8: Opcodes 0x0A (compare, first − second), 0x0B (compare negative, first + second), 0x08 (test, AND) and 0x09 (test equivalence, exclusive-or) never write and always update flags, whatever the set-flags bit is.
- R9: Whenever flags update, N is bit 31 of the computed value and Z is 1 exactly when the computed value is zero.
- R10: Opcode 0x10 writes the number of zero bits above the highest set bit of the first operand, 32 for a zero operand, and leaves all flags unchanged.
- R11: Opcodes 0x11–0x1F write nothing and leave the flags unchanged.
- R12: While rst_n is low at a clock edge, the result, the write enable and the flags are all cleared.
- R13: The outputs change only at the clock edge after the inputs are presented: one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 5 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| shc_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| setf_i | input | 1 | Set-flags request |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Registered destination write enable |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
A flag update and a result write fall in the same cycle for every arithmetic or logic opcode issued with set-flags. In that case the written value must also be the value that N and Z are derived from, and C must come from the adder or from the shifter depending on the class. Random opcodes, operands biased toward 0, all-ones and the sign boundaries, random incoming flags and a random set-flags bit are applied, and each registered output is compared one edge later with a bench model built on wide signed and unsigned integer arithmetic. Directed cases pin down carry, borrow and overflow at the 32-bit limits, and also cover compare issued with set-flags low and the leading-zero count at 0, 1 and the top bit.

// File: rtl/dp_alu_pkg.sv
// Package: shared opcode values, flag bit positions and opcode-class
// helpers for the data-processing ALU. Assumes a 5-bit opcode.
package dp_alu_pkg;

    localparam int OPW = 5;

    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    localparam logic [OPW-1:0] OP_AND = 5'h00;
    localparam logic [OPW-1:0] OP_EOR = 5'h01;
    localparam logic [OPW-1:0] OP_SUB = 5'h02;
    localparam logic [OPW-1:0] OP_RSB = 5'h03;
    localparam logic [OPW-1:0] OP_ADD = 5'h04;
    localparam logic [OPW-1:0] OP_ADC = 5'h05;
    localparam logic [OPW-1:0] OP_SBC = 5'h06;
    localparam logic [OPW-1:0] OP_RSC = 5'h07;
    localparam logic [OPW-1:0] OP_TST = 5'h08;
    localparam logic [OPW-1:0] OP_TEQ = 5'h09;
    localparam logic [OPW-1:0] OP_CMP = 5'h0A;
    localparam logic [OPW-1:0] OP_CMN = 5'h0B;
    localparam logic [OPW-1:0] OP_ORR = 5'h0C;
    localparam logic [OPW-1:0] OP_MOV = 5'h0D;
    localparam logic [OPW-1:0] OP_BIC = 5'h0E;
    localparam logic [OPW-1:0] OP_MVN = 5'h0F;
    localparam logic [OPW-1:0] OP_CLZ = 5'h10;

    // Adder-based opcodes, including the flag-only compares.
    function automatic logic is_arith(input logic [OPW-1:0] op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
    endfunction

    // Bitwise opcodes, including the flag-only tests.
    function automatic logic is_logic(input logic [OPW-1:0] op);
        return (op inside {OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN});
    endfunction

    // Flag-only opcodes: always update flags, never write.
    function automatic logic is_flag_only(input logic [OPW-1:0] op);
        return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
    endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
// Adder unit: maps every add, subtract, reverse-subtract and compare
// opcode onto one W+1 bit adder by selecting and inverting the inputs.
// Assumes subtraction carries an inverted borrow (C=1 means no borrow).
module dp_alu_addsub
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           cin_i,
    output logic [W-1:0]   sum_o,
    output logic           cout_o,
    output logic           ovf_o
);

    logic [W-1:0] x_s;
    logic [W-1:0] y_s;
    logic         ci_s;
    logic [W:0]   full_s;

    // Select adder operands and carry-in for the opcode.
    always_comb begin
        x_s  = a_i;
        y_s  = b_i;
        ci_s = 1'b0;
        case (op_i)
            OP_ADC:         ci_s = cin_i;
            OP_SUB, OP_CMP: begin y_s = ~b_i; ci_s = 1'b1;  end
            OP_SBC:         begin y_s = ~b_i; ci_s = cin_i; end
            OP_RSB:         begin x_s = b_i; y_s = ~a_i; ci_s = 1'b1;  end
            OP_RSC:         begin x_s = b_i; y_s = ~a_i; ci_s = cin_i; end
            default:        ;
        endcase
    end

    // Single adder with carry out and signed-overflow detection.
    always_comb begin
        full_s = {1'b0, x_s} + {1'b0, y_s} + {{W{1'b0}}, ci_s};
        sum_o  = full_s[W-1:0];
        cout_o = full_s[W];
        ovf_o  = (x_s[W-1] == y_s[W-1]) && (full_s[W-1] != x_s[W-1]);
    end

endmodule

// File: rtl/dp_alu_bitwise.sv
// Bitwise unit: AND, exclusive-or, OR, bit clear, move and move
// inverted; the test forms reuse AND and exclusive-or.
module dp_alu_bitwise
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o
);

    // Pick the bitwise function for the opcode.
    always_comb begin
        case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MOV:         res_o = b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_lzc.sv
// Leading-zero counter: number of zeros above the highest set bit,
// W for an all-zero input. Output width is derived from W.
module dp_alu_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val_i,
    output logic [CW-1:0] cnt_o
);

    // Scan upward; the highest set bit makes the last assignment.
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU top: combines the adder, bitwise and leading-zero
// units, derives write enable and next flags per opcode class, and
// registers all outputs (one cycle latency, synchronous active-low reset).
// Assumes the second operand and shifter carry arrive already computed.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [4:0]     op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic           shc_i,
    input  logic [3:0]     flags_i,
    input  logic           setf_i,
    output logic [W-1:0]   res_o,
    output logic           wr_o,
    output logic [3:0]     flags_o
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sum_s;
    logic          cout_s;
    logic          ovf_s;
    logic [W-1:0]  bit_s;
    logic [CW-1:0] lzc_s;
    logic          arith_s;
    logic          logic_s;
    logic          clz_s;
    logic [W-1:0]  res_c;
    logic          we_c;
    logic          upd_c;
    logic [3:0]    flags_c;

    dp_alu_addsub #(.W(W)) addsub_i (
        .op_i   (op_i),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (flags_i[FC]),
        .sum_o  (sum_s),
        .cout_o (cout_s),
        .ovf_o  (ovf_s)
    );

    dp_alu_bitwise #(.W(W)) bitwise_i (
        .op_i  (op_i),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (bit_s)
    );

    dp_alu_lzc #(.W(W), .CW(CW)) lzc_i (
        .val_i (opa_i),
        .cnt_o (lzc_s)
    );

    // Classify the opcode.
    always_comb begin
        arith_s = is_arith(op_i);
        logic_s = is_logic(op_i);
        clz_s   = (op_i == OP_CLZ);
    end

    // Select the result and decide write and flag update.
    always_comb begin
        if (arith_s)      res_c = sum_s;
        else if (logic_s) res_c = bit_s;
        else if (clz_s)   res_c = {{(W-CW){1'b0}}, lzc_s};
        else              res_c = '0;
        we_c  = ((arith_s || logic_s) && !is_flag_only(op_i)) || clz_s;
        upd_c = is_flag_only(op_i) || (setf_i && (arith_s || logic_s));
    end

    // Next flags: arithmetic takes adder C/V, logic takes shifter C and keeps V.
    always_comb begin
        flags_c = flags_i;
        if (upd_c) begin
            flags_c[FN] = res_c[W-1];
            flags_c[FZ] = (res_c == '0);
            flags_c[FC] = arith_s ? cout_s : shc_i;
            flags_c[FV] = arith_s ? ovf_s  : flags_i[FV];
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            wr_o    <= 1'b0;
            flags_o <= '0;
        end else begin
            res_o   <= res_c;
            wr_o    <= we_c;
            flags_o <= flags_c;
        end
    end

endmodule

// File: rtl/dp_alu_chk.sv
// Checker for dp_alu: relates the registered outputs to the inputs of
// the previous cycle. Attached by the bind statement at the end.
module dp_alu_chk
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [4:0]   op_i,
    input logic         shc_i,
    input logic [3:0]   flags_i,
    input logic         setf_i,
    input logic [W-1:0] res_o,
    input logic         wr_o,
    input logic [3:0]   flags_o
);

    // R8: flag-only opcodes never write.
    p_flagonly_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && is_flag_only($past(op_i)) |-> !wr_o);

    // R7: no set-flags on a writing data opcode keeps all flags.
    p_noset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(setf_i) && $past(op_i) < 5'h10 && !is_flag_only($past(op_i))
        |-> flags_o == $past(flags_i));

    // R6: logic/test updates take shifter carry and keep V.
    p_logic_cv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && is_logic($past(op_i)) && ($past(setf_i) || is_flag_only($past(op_i)))
        |-> flags_o[FC] == $past(shc_i) && flags_o[FV] == $past(flags_i[FV]));

    // R10: leading-zero count stays within 0..W, flags untouched, writes.
    p_clz_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == OP_CLZ
        |-> wr_o && res_o <= W && flags_o == $past(flags_i));

    // R9: Z flag agrees with the registered value whenever flags update.
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (is_flag_only($past(op_i)) ||
        ($past(setf_i) && (is_arith($past(op_i)) || is_logic($past(op_i)))))
        |-> flags_o[FZ] == (res_o == '0) && flags_o[FN] == res_o[W-1]);

    // R11: unassigned opcodes neither write nor change flags.
    p_unassigned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) > 5'h10 |-> !wr_o && flags_o == $past(flags_i));

endmodule

bind dp_alu dp_alu_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .shc_i   (shc_i),
    .flags_i (flags_i),
    .setf_i  (setf_i),
    .res_o   (res_o),
    .wr_o    (wr_o),
    .flags_o (flags_o)
);

// File: tb/dp_alu_tb_top.sv
// Bench for dp_alu: directed corners plus seeded random stimulus,
// each compared one clock edge later with a wide-integer model.
module dp_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        shc_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic        setf_i = 1'b0;
    logic [31:0] res_o;
    logic        wr_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dp_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .shc_i(shc_i), .flags_i(flags_i), .setf_i(setf_i),
        .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o)
    );

    // Requirement tag for an opcode.
    function automatic string tag(input logic [4:0] op);
        case (op)
            5'h04, 5'h05:               return "R1";
            5'h02, 5'h06:               return "R2";
            5'h03, 5'h07:               return "R3";
            5'h00, 5'h01, 5'h0C, 5'h0E: return "R4";
            5'h0D, 5'h0F:               return "R5";
            5'h08, 5'h09, 5'h0A, 5'h0B: return "R8";
            5'h10:                      return "R10";
            default:                    return "R11";
        endcase
    endfunction

    // Reference model built from the requirement text.
    function automatic void model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                                  input logic shc, input logic [3:0] f, input logic setf,
                                  output logic [31:0] r, output logic we, output logic [3:0] nf);
        longint ua = longint'({32'b0, a});
        longint ub = longint'({32'b0, b});
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint cf = longint'(f[1]);
        longint bw = 1 - cf;
        longint uu = 0;
        longint ss = 0;
        bit ar = 0, lg = 0, fo = 0;
        logic c = 0;
        r = '0; we = 0; nf = f;
        case (op)
            5'h04, 5'h0B: begin uu = ua + ub;      ss = sa + sb;      c = uu[32]; ar = 1; end
            5'h05:        begin uu = ua + ub + cf; ss = sa + sb + cf; c = uu[32]; ar = 1; end
            5'h02, 5'h0A: begin uu = ua - ub;      ss = sa - sb;      c = (ua >= ub); ar = 1; end
            5'h06:        begin uu = ua - ub - bw; ss = sa - sb - bw; c = (ua >= ub + bw); ar = 1; end
            5'h03:        begin uu = ub - ua;      ss = sb - sa;      c = (ub >= ua); ar = 1; end
            5'h07:        begin uu = ub - ua - bw; ss = sb - sa - bw; c = (ub >= ua + bw); ar = 1; end
            5'h00, 5'h08: begin r = a & b;  lg = 1; end
            5'h01, 5'h09: begin r = a ^ b;  lg = 1; end
            5'h0C:        begin r = a | b;  lg = 1; end
            5'h0E:        begin r = a & ~b; lg = 1; end
            5'h0D:        begin r = b;      lg = 1; end
            5'h0F:        begin r = ~b;     lg = 1; end
            5'h10: begin
                r = 32;
                for (int i = 31; i >= 0; i--) if (a[i]) begin r = 31 - i; break; end
                we = 1;
            end
            default: ;
        endcase
        fo = (op >= 5'h08 && op <= 5'h0B);
        if (ar) r = uu[31:0];
        if (ar || lg) begin
            we = !fo;
            if (fo || setf) begin
                nf[3] = r[31];
                nf[2] = (r == 0);
                nf[1] = ar ? c : shc;
                nf[0] = ar ? (ss > 64'sd2147483647 || ss < -64'sd2147483648) : f[0];
            end
        end
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, sample at the next falling edge.
    task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic shc, input logic [3:0] f, input logic setf);
        logic [31:0] er;
        logic ew;
        logic [3:0] ef;
        op_i = op; opa_i = a; opb_i = b; shc_i = shc; flags_i = f; setf_i = setf;
        model(op, a, b, shc, f, setf, er, ew, ef);
        @(negedge clk);
        check(tag(op), "write", {63'b0, wr_o}, {63'b0, ew});
        check((setf || tag(op) == "R8") ? "R9" : "R7", "flags", {60'b0, flags_o}, {60'b0, ef});
        if (ew) check(tag(op), "result", {32'b0, res_o}, {32'b0, er});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'h1 << $urandom_range(0, 31);
            default: return $urandom();
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A1B));
        repeat (3) @(negedge clk);
        // R12: reset clears the registered outputs.
        check("R12", "result", {32'b0, res_o}, 64'h0);
        check("R12", "write", {63'b0, wr_o}, 64'h0);
        check("R12", "flags", {60'b0, flags_o}, 64'h0);
        rst_n = 1'b1;

        // R1: overflow to sign and unsigned wrap to zero.
        run(5'h04, 32'h7FFF_FFFF, 32'h1, 0, 4'h0, 1);
        run(5'h04, 32'hFFFF_FFFF, 32'h1, 0, 4'h0, 1);
        run(5'h05, 32'hFFFF_FFFE, 32'h1, 0, 4'h2, 1);
        // R2: equal operands, borrow, carry-chained borrow.
        run(5'h02, 32'd5, 32'd5, 0, 4'h0, 1);
        run(5'h02, 32'd3, 32'd5, 0, 4'h0, 1);
        run(5'h06, 32'd5, 32'd5, 0, 4'h0, 1);
        run(5'h02, 32'h8000_0000, 32'h1, 0, 4'h0, 1);
        // R3: reverse forms.
        run(5'h03, 32'd4, 32'd12, 0, 4'h0, 1);
        run(5'h07, 32'd4, 32'd12, 0, 4'h0, 1);
        // R4, R5, R6: logic results, shifter carry, V held.
        run(5'h0E, 32'hFF00_FF00, 32'h0F0F_0F0F, 1, 4'h1, 1);
        run(5'h0F, 32'h0, 32'h0, 1, 4'h1, 1);
        run(5'h0D, 32'h0, 32'h0, 0, 4'h3, 1);
        // R7: no set-flags keeps flags.
        run(5'h04, 32'hFFFF_FFFF, 32'h1, 0, 4'hA, 0);
        // R8: compare with set-flags low still updates, never writes.
        run(5'h0A, 32'd7, 32'd7, 0, 4'h0, 0);
        run(5'h09, 32'h1234, 32'h1234, 1, 4'h1, 0);
        // R10: leading-zero count corners.
        run(5'h10, 32'h0, 32'h0, 0, 4'hF, 1);
        run(5'h10, 32'h1, 32'h0, 0, 4'h5, 1);
        run(5'h10, 32'h8000_0000, 32'h0, 0, 4'h0, 1);
        // R11: unassigned opcodes.
        run(5'h1F, 32'h1, 32'h1, 1, 4'h6, 1);
        run(5'h11, 32'h0, 32'h0, 0, 4'h9, 1);

        // R13: output holds until the next rising edge.
        run(5'h0D, 32'hAAAA_5555, 32'hCAFE_F00D, 0, 4'h0, 0);
        op_i = 5'h0D; opb_i = 32'h0BAD_BEEF;
        #5;
        check("R13", "held result", {32'b0, res_o}, {32'b0, 32'hCAFE_F00D});
        @(negedge clk);
        check("R13", "new result", {32'b0, res_o}, {32'b0, 32'h0BAD_BEEF});

        // Random mix across all opcodes, including unassigned ones.
        for (int n = 0; n < 3000; n++) begin
            run(5'($urandom_range(0, 20)), pick(), pick(), 1'($urandom_range(0, 1)),
                4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
        end

        // R12: reset in mid-stream.
        rst_n = 1'b0;
        op_i = 5'h0F; opb_i = 32'h0; setf_i = 1'b1;
        @(negedge clk);
        check("R12", "write after reset", {63'b0, wr_o}, 64'h0);
        check("R12", "flags after reset", {60'b0, flags_o}, 64'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule